// File: doc/BRIEF.md
# Segmented time-slot bus arbiter

This block hands a shared bus to one of several processors by following a fixed schedule instead of reacting to who asks first. The schedule spans one application period and restarts from its beginning when the period runs out. The period is split into segments. Inside a segment, a short list of owner entries repeats: each entry names the processor that owns the bus for that slot, and the slot lasts a programmed number of cycles. A processor that asks for the bus outside its own slot waits for its next slot. Because a slot is never lent to anyone else, the cycle at which a processor is served depends only on the schedule, the time and that processor's own requests.

The schedule lives in a small table inside the arbiter. It is loaded through a write port while the arbiter is disabled. A parameter selects how slot lengths are held. In per-owner sizing, each segment keeps one length for each processor. In uniform sizing, each segment keeps a single length for all its slots. In fixed sizing, segment 0 alone describes the whole period. Each grant covers one cache-line transfer of a fixed number of cycles. A transfer is started only if it will finish inside the owner's current slot.

Top module: `tdma_seg_arbiter`

## Requirements
- R1: Table writes (field code 0 = segment start time, 1 = index of the segment's last owner entry, 2 = owner of entry `wr_idx`, 3 = slot length at `wr_idx`) take effect only while `en` is low. A write made while `en` is high changes nothing.
- R2: While `en` is low, no grant or done is raised and the schedule position is held at time 0, segment 0, entry 0. The first cycle with `en` high is time 0 of the period.
- R3: The time advances by one each enabled cycle. After time `cfg_period`-1 it returns to time 0, segment 0, entry 0.
- R4: In per-owner and uniform sizing, when the time reaches the start time of the next segment, and that segment's number is below `cfg_seg_cnt`, the schedule moves to that segment at entry 0. This cuts short the slot in progress.
- R5: Within a segment, the owner entries are walked from 0 up to the segment's last index and then from 0 again. Each slot lasts its programmed length (at least 1).
- R6: In per-owner sizing, the length of a slot is the length stored at the owning processor's number within the current segment.
- R7: In uniform sizing, every slot of a segment takes the length stored at index 0 of that segment.
- R8: In fixed sizing, segment start times and `cfg_seg_cnt` are ignored. Segment 0's owner list and its index-0 length run over the whole period.
- R9: At most one grant is high at a time. A grant starts only for the processor that owns the current slot and is requesting.
- R10: A transfer starts in the cycle after a decision cycle. It is started only if the cycles left in the slot, counting the decision cycle and bounded by the next segment start and the period end, exceed `XFER_CYCLES`. Otherwise the request waits for the owner's next slot.
- R11: A grant stays high for exactly `XFER_CYCLES` cycles, with done high in its last cycle. The cycle after done carries no grant.
- R12: A request from one processor never advances or delays the grant of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Arbitration enable; low holds the schedule at its start and opens the table for writes |
| cfg_period | input | TIME_W | Period length in cycles |
| cfg_seg_cnt | input | $clog2(N_SEG+1) | Number of segments in use |
| wr_en | input | 1 | Table write strobe |
| wr_field | input | 2 | Field code of the write (see R1) |
| wr_seg | input | $clog2(N_SEG) | Segment addressed by the write |
| wr_idx | input | max($clog2(N_SLOT),$clog2(N_PROC)) | Owner entry or length index |
| wr_data | input | TIME_W | Value written |
| req | input | N_PROC | Per-processor transfer request, held until done |
| grant | output | N_PROC | Per-processor bus grant |
| done | output | N_PROC | Last cycle of the granted transfer |

## Verification
The hardest situation to reach is a request that arrives close to the end of a slot. Such a request must be refused, and the refusal must hold when the slot is cut short by a segment start or by the period end rather than by its own length. The schedule is built so that several slots end in each of these three ways, with one slot just one cycle longer than a transfer. Pseudo-random requests then arrive at every offset within those slots. Three copies of the block, one per sizing variant, run the same table, each against a behavioural model compared on every cycle. A write made while the block is enabled, and a change to the table between two enabled runs, show whether writes are gated correctly.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
   typedef enum logic [1:0] {
      FLD_SEG_START  = 2'd0,
      FLD_LAST_SLOT  = 2'd1,
      FLD_SLOT_OWNER = 2'd2,
      FLD_SLOT_SIZE  = 2'd3
   } tdma_field_e;

   typedef enum int {
      SZ_PER_OWNER = 0,
      SZ_UNIFORM   = 1,
      SZ_FIXED     = 2
   } tdma_sizing_e;
endpackage

// File: rtl/tdma_slot_table.sv
module tdma_slot_table
   import tdma_pkg::*;
#(
   parameter int N_PROC = 3,
   parameter int N_SEG  = 4,
   parameter int N_SLOT = 4,
   parameter int TIME_W = 16,
   parameter int SIZE_W = 8,
   parameter tdma_sizing_e SIZING = SZ_PER_OWNER,
   localparam int PID_W  = $clog2(N_PROC),
   localparam int SEG_W  = $clog2(N_SEG),
   localparam int SLOT_W = $clog2(N_SLOT),
   localparam int IDX_W  = (SLOT_W > PID_W) ? SLOT_W : PID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic              wr_en,
   input  tdma_field_e       wr_field,
   input  logic [SEG_W-1:0]  wr_seg,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TIME_W-1:0] wr_data,
   input  logic [SEG_W-1:0]  rd_seg,
   input  logic [SLOT_W-1:0] rd_idx,
   output logic [PID_W-1:0]  rd_owner,
   output logic [SLOT_W-1:0] rd_last,
   output logic [SIZE_W-1:0] rd_size,
   output logic [TIME_W-1:0] rd_next_start
);
   localparam logic [IDX_W:0] SLOT_LIM = (IDX_W+1)'(N_SLOT);
   localparam logic [IDX_W:0] PROC_LIM = (IDX_W+1)'(N_PROC);

   logic [TIME_W-1:0] seg_start [N_SEG];
   logic [SLOT_W-1:0] seg_last  [N_SEG];
   logic [PID_W-1:0]  slot_own  [N_SEG][N_SLOT];
   logic [SIZE_W-1:0] slot_len  [N_SEG][N_PROC];
   logic [IDX_W:0]    idx_wide;
   logic [SEG_W-1:0]  seg_up;

   assign idx_wide = {1'b0, wr_idx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < N_SEG; s++) begin
            seg_start[s] <= '0;
            seg_last[s]  <= '0;
            for (int e = 0; e < N_SLOT; e++) slot_own[s][e] <= '0;
            for (int p = 0; p < N_PROC; p++) slot_len[s][p] <= '0;
         end
      end else if (wr_ok && wr_en) begin
         case (wr_field)
            FLD_SEG_START:  seg_start[wr_seg] <= wr_data;
            FLD_LAST_SLOT:  seg_last[wr_seg]  <= wr_data[SLOT_W-1:0];
            FLD_SLOT_OWNER: if (idx_wide < SLOT_LIM)
                               slot_own[wr_seg][wr_idx[SLOT_W-1:0]] <= wr_data[PID_W-1:0];
            FLD_SLOT_SIZE:  if (idx_wide < PROC_LIM)
                               slot_len[wr_seg][wr_idx[PID_W-1:0]] <= wr_data[SIZE_W-1:0];
            default: ;
         endcase
      end
   end

   assign seg_up        = rd_seg + 1'b1;
   assign rd_owner      = slot_own[rd_seg][rd_idx];
   assign rd_last       = seg_last[rd_seg];
   assign rd_next_start = seg_start[seg_up];

   generate
      if (SIZING == SZ_PER_OWNER) begin : g_len_owner
         assign rd_size = slot_len[rd_seg][rd_owner];
      end else begin : g_len_shared
         assign rd_size = slot_len[rd_seg][0];
      end
   endgenerate
endmodule

// File: rtl/tdma_timebase.sv
module tdma_timebase
   import tdma_pkg::*;
#(
   parameter int N_SEG  = 4,
   parameter int N_SLOT = 4,
   parameter int TIME_W = 16,
   parameter int SIZE_W = 8,
   parameter tdma_sizing_e SIZING = SZ_PER_OWNER,
   localparam int SEG_W  = $clog2(N_SEG),
   localparam int SEGC_W = $clog2(N_SEG + 1),
   localparam int SLOT_W = $clog2(N_SLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [TIME_W-1:0] cfg_period,
   input  logic [SEGC_W-1:0] cfg_seg_cnt,
   input  logic [SLOT_W-1:0] slot_last,
   input  logic [SIZE_W-1:0] slot_size,
   input  logic [TIME_W-1:0] next_start,
   output logic [TIME_W-1:0] cur_time,
   output logic [SEG_W-1:0]  cur_seg,
   output logic [SLOT_W-1:0] cur_idx,
   output logic [TIME_W:0]   room
);
   logic [TIME_W-1:0] time_q, t_inc;
   logic [SEG_W-1:0]  seg_q;
   logic [SLOT_W-1:0] idx_q;
   logic [SIZE_W-1:0] el_q;
   logic              seg_more, wrap, seg_cross, slot_done;
   logic [TIME_W:0]   sz_left, per_left, seg_left, room_a;

   generate
      if (SIZING == SZ_FIXED) begin : g_no_seg
         assign seg_more = 1'b0;
      end else begin : g_seg
         assign seg_more = (SEGC_W'(seg_q) + 1'b1) < cfg_seg_cnt;
      end
   endgenerate

   assign t_inc     = time_q + 1'b1;
   assign wrap      = (time_q == cfg_period - 1'b1);
   assign seg_cross = seg_more && (t_inc == next_start);
   assign slot_done = (el_q == slot_size - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_q <= '0; seg_q <= '0; idx_q <= '0; el_q <= '0;
      end else if (!en || wrap) begin
         time_q <= '0; seg_q <= '0; idx_q <= '0; el_q <= '0;
      end else begin
         time_q <= t_inc;
         if (seg_cross) begin
            seg_q <= seg_q + 1'b1;
            idx_q <= '0;
            el_q  <= '0;
         end else if (slot_done) begin
            el_q  <= '0;
            idx_q <= (idx_q == slot_last) ? '0 : idx_q + 1'b1;
         end else begin
            el_q  <= el_q + 1'b1;
         end
      end
   end

   assign sz_left  = {{(TIME_W+1-SIZE_W){1'b0}}, slot_size - el_q};
   assign per_left = {1'b0, cfg_period} - {1'b0, time_q};
   assign seg_left = {1'b0, next_start} - {1'b0, time_q};
   assign room_a   = (seg_more && seg_left < sz_left) ? seg_left : sz_left;
   assign room     = (per_left < room_a) ? per_left : room_a;

   assign cur_time = time_q;
   assign cur_seg  = seg_q;
   assign cur_idx  = idx_q;
endmodule

// File: rtl/tdma_grant_ctrl.sv
module tdma_grant_ctrl #(
   parameter int N_PROC      = 3,
   parameter int TIME_W      = 16,
   parameter int XFER_CYCLES = 12,
   localparam int PID_W = $clog2(N_PROC),
   localparam int CNT_W = $clog2(XFER_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [N_PROC-1:0] req,
   input  logic [PID_W-1:0]  owner,
   input  logic [TIME_W:0]   room,
   output logic [N_PROC-1:0] grant,
   output logic [N_PROC-1:0] done
);
   localparam logic [TIME_W:0] XFER_L = (TIME_W+1)'(XFER_CYCLES);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(XFER_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic [PID_W-1:0] gown_q;
   logic             launch;

   assign launch = en && (cnt_q == '0) && req[owner] && (room > XFER_L);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         gown_q <= '0;
      end else if (!en) begin
         cnt_q  <= '0;
      end else if (launch) begin
         cnt_q  <= CNT_FULL;
         gown_q <= owner;
      end else if (cnt_q != '0) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < N_PROC; i++) begin : g_out
         assign grant[i] = (cnt_q != '0) && (gown_q == PID_W'(i));
         assign done[i]  = grant[i] && (cnt_q == CNT_W'(1));
      end
   endgenerate
endmodule

// File: rtl/tdma_seg_arbiter.sv
module tdma_seg_arbiter
   import tdma_pkg::*;
#(
   parameter int N_PROC      = 3,
   parameter int N_SEG       = 4,
   parameter int N_SLOT      = 4,
   parameter int TIME_W      = 16,
   parameter int SIZE_W      = 8,
   parameter int XFER_CYCLES = 12,
   parameter tdma_sizing_e SIZING = SZ_PER_OWNER,
   localparam int PID_W  = $clog2(N_PROC),
   localparam int SEG_W  = $clog2(N_SEG),
   localparam int SEGC_W = $clog2(N_SEG + 1),
   localparam int SLOT_W = $clog2(N_SLOT),
   localparam int IDX_W  = (SLOT_W > PID_W) ? SLOT_W : PID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [TIME_W-1:0] cfg_period,
   input  logic [SEGC_W-1:0] cfg_seg_cnt,
   input  logic              wr_en,
   input  logic [1:0]        wr_field,
   input  logic [SEG_W-1:0]  wr_seg,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TIME_W-1:0] wr_data,
   input  logic [N_PROC-1:0] req,
   output logic [N_PROC-1:0] grant,
   output logic [N_PROC-1:0] done
);
   generate
      if (N_PROC < 2)          begin : g_bad_proc $error("N_PROC must be at least 2"); end
      if (N_SEG < 2)           begin : g_bad_seg  $error("N_SEG must be at least 2"); end
      if (N_SLOT < 2)          begin : g_bad_slot $error("N_SLOT must be at least 2"); end
      if (SIZE_W > TIME_W)     begin : g_bad_size $error("SIZE_W must not exceed TIME_W"); end
      if (XFER_CYCLES < 1)     begin : g_bad_xfer $error("XFER_CYCLES must be positive"); end
   endgenerate

   logic [TIME_W-1:0] cur_time, next_start;
   logic [SEG_W-1:0]  cur_seg;
   logic [SLOT_W-1:0] cur_idx, slot_last;
   logic [PID_W-1:0]  cur_owner;
   logic [SIZE_W-1:0] slot_size;
   logic [TIME_W:0]   room;

   tdma_slot_table #(
      .N_PROC(N_PROC), .N_SEG(N_SEG), .N_SLOT(N_SLOT),
      .TIME_W(TIME_W), .SIZE_W(SIZE_W), .SIZING(SIZING)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .wr_ok(!en), .wr_en(wr_en),
      .wr_field(tdma_field_e'(wr_field)), .wr_seg(wr_seg), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_seg(cur_seg), .rd_idx(cur_idx),
      .rd_owner(cur_owner), .rd_last(slot_last), .rd_size(slot_size),
      .rd_next_start(next_start)
   );

   tdma_timebase #(
      .N_SEG(N_SEG), .N_SLOT(N_SLOT), .TIME_W(TIME_W),
      .SIZE_W(SIZE_W), .SIZING(SIZING)
   ) u_time (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_period(cfg_period),
      .cfg_seg_cnt(cfg_seg_cnt), .slot_last(slot_last), .slot_size(slot_size),
      .next_start(next_start), .cur_time(cur_time), .cur_seg(cur_seg),
      .cur_idx(cur_idx), .room(room)
   );

   tdma_grant_ctrl #(
      .N_PROC(N_PROC), .TIME_W(TIME_W), .XFER_CYCLES(XFER_CYCLES)
   ) u_grant (
      .clk(clk), .rst_n(rst_n), .en(en), .req(req), .owner(cur_owner),
      .room(room), .grant(grant), .done(done)
   );
endmodule

// File: rtl/tdma_seg_arbiter_chk.sv
module tdma_seg_arbiter_chk #(
   parameter int N_PROC      = 3,
   parameter int TIME_W      = 16,
   parameter int SEG_W       = 2,
   parameter int PID_W       = 2,
   parameter int XFER_CYCLES = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [TIME_W-1:0] cfg_period,
   input logic [N_PROC-1:0] req,
   input logic [N_PROC-1:0] grant,
   input logic [N_PROC-1:0] done,
   input logic [PID_W-1:0]  owner,
   input logic [TIME_W:0]   room,
   input logic [TIME_W-1:0] t_now,
   input logic [SEG_W-1:0]  seg_now
);
   localparam logic [TIME_W:0] XFER_L = (TIME_W+1)'(XFER_CYCLES);

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R9

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (grant == '0 && t_now == '0 && seg_now == '0)); // R2

   AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && t_now == cfg_period - 1'b1) |=> (t_now == '0 && seg_now == '0)); // R3

   generate
      for (genvar i = 0; i < N_PROC; i++) begin : g_p
         AST_START_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant[i]) |-> ($past(owner) == PID_W'(i) && $past(req[i]))); // R9
         AST_START_FITS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant[i]) |-> ($past(room) > XFER_L)); // R10
         AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (en && grant[i] && !done[i]) |=> grant[i]); // R11
         AST_DONE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |-> grant[i]); // R11
         AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |=> (grant == '0)); // R11
      end
   endgenerate
endmodule

bind tdma_seg_arbiter tdma_seg_arbiter_chk #(
   .N_PROC(N_PROC), .TIME_W(TIME_W), .SEG_W(SEG_W),
   .PID_W(PID_W), .XFER_CYCLES(XFER_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .cfg_period(cfg_period),
   .req(req), .grant(grant), .done(done), .owner(cur_owner),
   .room(room), .t_now(cur_time), .seg_now(cur_seg)
);

// File: tb/tdma_seg_arbiter_test.sv
`timescale 1ns/1ps
module tdma_seg_arbiter_test;
   import tdma_pkg::*;

   localparam int XF = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [15:0]      cfg_period = 16'd160;
   logic [2:0]       cfg_seg_cnt = 3'd3;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_field = 2'd0;
   logic [1:0]       wr_seg = 2'd0;
   logic [1:0]       wr_idx = 2'd0;
   logic [15:0]      wr_data = 16'd0;
   logic [2:0][2:0]  rq, gnt, dn;

   always #10 clk = ~clk;

   tdma_seg_arbiter #(.SIZING(SZ_PER_OWNER)) uut (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_period(cfg_period),
      .cfg_seg_cnt(cfg_seg_cnt), .wr_en(wr_en), .wr_field(wr_field),
      .wr_seg(wr_seg), .wr_idx(wr_idx), .wr_data(wr_data),
      .req(rq[0]), .grant(gnt[0]), .done(dn[0]));
   tdma_seg_arbiter #(.SIZING(SZ_UNIFORM)) uut_uni (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_period(cfg_period),
      .cfg_seg_cnt(cfg_seg_cnt), .wr_en(wr_en), .wr_field(wr_field),
      .wr_seg(wr_seg), .wr_idx(wr_idx), .wr_data(wr_data),
      .req(rq[1]), .grant(gnt[1]), .done(dn[1]));
   tdma_seg_arbiter #(.SIZING(SZ_FIXED)) uut_fix (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_period(cfg_period),
      .cfg_seg_cnt(cfg_seg_cnt), .wr_en(wr_en), .wr_field(wr_field),
      .wr_seg(wr_seg), .wr_idx(wr_idx), .wr_data(wr_data),
      .req(rq[2]), .grant(gnt[2]), .done(dn[2]));

   int n_chk = 0, n_fail = 0;
   bit fin = 1'b0, cmp_on = 1'b0;
   string ph = "";
   string tg [3] = '{"R3 R4 R5 R6 R9 R10 R11 R12",
                     "R3 R4 R5 R7 R9 R10 R11 R12",
                     "R3 R5 R8 R9 R10 R11 R12"};

   // reference schedule table as written while disabled
   int st [4], lst [4], own [4][4], sz [4][3];
   // reference state per copy
   int mt [3], ms [3], mi [3], me [3], mc [3], mg [3];
   int served [3][3];
   int unsigned rnd = 32'h1234_5678;

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic model_step(input int k);
      int o, size, nst, rem;
      bit segmore, start;
      if (!en) begin
         mt[k] = 0; ms[k] = 0; mi[k] = 0; me[k] = 0; mc[k] = 0;
         return;
      end
      o = own[ms[k]][mi[k]];
      size = (k == 0) ? sz[ms[k]][o] : sz[ms[k]][0];
      segmore = (k != 2) && (ms[k] + 1 < int'(cfg_seg_cnt));
      nst = (ms[k] + 1 < 4) ? st[ms[k] + 1] : st[0];
      rem = size - me[k];
      if (segmore && (nst - mt[k]) < rem) rem = nst - mt[k];
      if ((int'(cfg_period) - mt[k]) < rem) rem = int'(cfg_period) - mt[k];
      start = (mc[k] == 0) && rq[k][o] && (rem > XF);
      if (start) begin mc[k] = XF; mg[k] = o; end
      else if (mc[k] > 0) mc[k]--;
      if (mt[k] == int'(cfg_period) - 1) begin
         mt[k] = 0; ms[k] = 0; mi[k] = 0; me[k] = 0;
      end else begin
         mt[k]++;
         if (segmore && mt[k] == nst) begin
            ms[k]++; mi[k] = 0; me[k] = 0;
         end else if (me[k] == size - 1) begin
            me[k] = 0;
            mi[k] = (mi[k] == lst[ms[k]]) ? 0 : mi[k] + 1;
         end else me[k]++;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < 4; s++) begin
            st[s] = 0; lst[s] = 0;
            for (int e = 0; e < 4; e++) own[s][e] = 0;
            for (int p = 0; p < 3; p++) sz[s][p] = 0;
         end
         for (int k = 0; k < 3; k++) begin
            mt[k] = 0; ms[k] = 0; mi[k] = 0; me[k] = 0; mc[k] = 0; mg[k] = 0;
         end
      end else begin
         for (int k = 0; k < 3; k++) model_step(k);
         if (wr_en && !en) begin
            case (wr_field)
               2'd0: st[wr_seg] = int'(wr_data);
               2'd1: lst[wr_seg] = int'(wr_data[1:0]);
               2'd2: own[wr_seg][wr_idx] = int'(wr_data[1:0]);
               default: if (wr_idx < 2'd3) sz[wr_seg][wr_idx] = int'(wr_data[7:0]);
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         for (int k = 0; k < 3; k++) begin
            int eg, ed;
            eg = (mc[k] > 0) ? (1 << mg[k]) : 0;
            ed = (mc[k] == 1) ? (1 << mg[k]) : 0;
            check(int'(gnt[k]) == eg, $sformatf("%s %s copy %0d grant", tg[k], ph, k), int'(gnt[k]), eg);
            check(int'(dn[k]) == ed, $sformatf("%s %s copy %0d done", tg[k], ph, k), int'(dn[k]), ed);
            for (int i = 0; i < 3; i++) if (dn[k][i]) served[k][i]++;
         end
      end
      rnd = rnd ^ (rnd << 13);
      rnd = rnd ^ (rnd >> 17);
      rnd = rnd ^ (rnd << 5);
      for (int k = 0; k < 3; k++)
         for (int i = 0; i < 3; i++) begin
            if (rq[k][i] && dn[k][i]) rq[k][i] = 1'b0;
            else if (!rq[k][i] && rnd[2*(3*k+i) +: 2] == 2'b00) rq[k][i] = 1'b1;
         end
   end

   task automatic wr(input int f, input int sg, input int ix, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_field = f[1:0]; wr_seg = sg[1:0];
      wr_idx = ix[1:0]; wr_data = d[15:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      rq = '0;
      for (int k = 0; k < 3; k++) for (int i = 0; i < 3; i++) served[k][i] = 0;
      repeat (4) @(negedge clk);
      // R2: outputs quiet in reset
      for (int k = 0; k < 3; k++) check(gnt[k] == 3'b0, "R2 grant during reset", int'(gnt[k]), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 3; k++) check(dn[k] == 3'b0, "R2 done after reset", int'(dn[k]), 0);
      // R1: table loaded while disabled
      wr(0, 1, 0, 70);  wr(0, 2, 0, 120);
      wr(1, 0, 0, 2);   wr(1, 1, 0, 1);   wr(1, 2, 0, 0);
      wr(2, 0, 0, 0);   wr(2, 0, 1, 1);   wr(2, 0, 2, 2);
      wr(2, 1, 0, 1);   wr(2, 1, 1, 0);   wr(2, 2, 0, 2);
      wr(3, 0, 0, 20);  wr(3, 0, 1, 14);  wr(3, 0, 2, 13);
      wr(3, 1, 0, 30);  wr(3, 1, 1, 16);  wr(3, 1, 2, 9);
      wr(3, 2, 0, 25);  wr(3, 2, 1, 10);  wr(3, 2, 2, 25);
      cmp_on = 1'b1;
      ph = "R2 disabled";
      repeat (30) @(negedge clk);
      ph = "";
      en = 1'b1;
      repeat (500) @(negedge clk);
      // R1: writes while enabled must not alter the schedule
      ph = "R1 write-while-enabled";
      wr(2, 0, 0, 2);
      wr(0, 1, 0, 50);
      wr(3, 0, 1, 40);
      repeat (700) @(negedge clk);
      en = 1'b0;
      ph = "R2 disabled";
      repeat (10) @(negedge clk);
      wr(2, 0, 0, 2);
      wr(1, 2, 0, 1);
      wr(2, 2, 1, 0);
      ph = "R1 reprogrammed";
      en = 1'b1;
      repeat (900) @(negedge clk);
      // R9: every processor is eventually served in every variant
      for (int k = 0; k < 3; k++)
         for (int i = 0; i < 3; i++)
            check(served[k][i] > 0, $sformatf("R9 service copy %0d proc %0d", k, i), served[k][i], 1);
      fin = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_chk++; n_fail++;
         $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 150000, 0);
         summary();
         $finish;
      end
   end
endmodule